// File: doc/BRIEF.md
# Double-Buffered Clock Register Bank

This block sits between a byte-wide bus port and a calendar counter. It maps eight byte registers onto the highest eight addresses of the bus address space. One control byte sits at the lowest of those eight addresses, and seven time fields sit above it: seconds, minutes, hours, day of week, date, month, year. Bus reads never see the live counters directly. They see a holding copy that refreshes from the live counters on each one-second tick.

Software can freeze the holding copy in two ways. With the halt-for-read bit set, the copy keeps the time that was current when the bit was set, while the counters keep running. With the halt-for-write bit set, the copy is also frozen, and software can write new BCD values into it. Clearing the halt-for-write bit issues a one-cycle load strobe that carries the whole copy into the counters.

Two configuration flags share bytes with the time fields. One is an oscillator-stop flag, held in the top bit of the seconds byte. The other is a frequency-test flag, held in bit 6 of the day byte. With the frequency test on and the oscillator running, bit 0 of the seconds byte shows a test tone instead of the stored value.

Top module: `clkbank_top`

## Requirements
- R1: `bus_hit` is high exactly when every address bit above the low three is 1. Any other address reads 0 and ignores writes. Within the window, address bits 2:0 select control (0), seconds (1), minutes (2), hours (3), day (4), date (5), month (6), year (7).
- R2: With both halt bits clear and no load in progress, a `sec_tick` copies `live_time` into the holding copy. The copy is visible one cycle later. `live_time` packs seconds in bits 7:0 and each later field in the next byte up, with year in bits 55:48.
- R3: While the halt-for-read bit (control bit 6) is set, the visible time fields do not change across ticks.
- R4: Clearing the halt-for-read bit does not refresh the copy at once. The copy resumes tracking on the next tick.
- R5: While the halt-for-write bit (control bit 7) is set, ticks are ignored and writes to the time fields land in the copy. While it is clear, writes leave the time fields unchanged.
- R6: A control write with bit 7 = 0, made while the halt-for-write bit is set, raises `load_stb` for exactly one cycle. During that cycle `load_time` holds the written fields, in the R2 packing.
- R7: The control byte reads {halt-for-write, halt-for-read, 000000}.
- R8: Unused bits store and read as 0. The field widths are 7, 7, 6, 3, 6, 5 and 8 bits, from seconds up to year.
- R9: Seconds bit 7 is the oscillator-stop flag. It is writable at any time, drives `osc_stop` and reads back.
- R10: Day bit 6 is the frequency-test flag. It is writable at any time, drives `freq_test` and reads back. When it is 1 and `osc_stop` is 0, seconds bit 0 reads `test_tone`.
- R11: After reset, every register reads 0 and `load_stb`, `osc_stop` and `freq_test` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| bus_hit | output | 1 | Address falls inside the register window |
| sec_tick | input | 1 | One-cycle pulse when the live counters advance |
| test_tone | input | 1 | Test tone shown on seconds bit 0 in frequency-test mode |
| live_time | input | 56 | Live counter fields from the calendar counter |
| load_stb | output | 1 | One-cycle strobe to load the counters |
| load_time | output | 56 | Values to load, same packing as live_time |
| osc_stop | output | 1 | Oscillator-stop flag |
| freq_test | output | 1 | Frequency-test flag |

## Verification
The bench builds the block with its default 11-bit address. At that width it can sweep every address to check the window decode and the isolation of the rest of the map. It writes all-ones into every time field to show each field mask. It pushes 32 computed live patterns through the tick path. Its fixed sequences cover freeze, late resume, writes ignored outside write mode, the bulk load, and the tone override with the oscillator both running and stopped.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
    localparam int BYTE_W = 8;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int NTIME  = NREG - 1;
    localparam int TIME_W = NTIME * BYTE_W;

    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DOW_W   = 3;
    localparam int DATE_W  = 6;
    localparam int MONTH_W = 5;
    localparam int YEAR_W  = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL = 0;
    localparam logic [IDX_W-1:0] IDX_SEC  = 1;
    localparam logic [IDX_W-1:0] IDX_DOW  = 4;

    function automatic logic [BYTE_W-1:0] width_mask(input int unsigned w);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < BYTE_W; b++) begin
            if (b < w) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] field_mask(input int unsigned idx);
        case (idx)
            1:       return width_mask(SEC_W);
            2:       return width_mask(MIN_W);
            3:       return width_mask(HOUR_W);
            4:       return width_mask(DOW_W);
            5:       return width_mask(DATE_W);
            6:       return width_mask(MONTH_W);
            7:       return width_mask(YEAR_W);
            default: return '0;
        endcase
    endfunction

    function automatic logic [TIME_W-1:0] time_mask();
        logic [TIME_W-1:0] m;
        m = '0;
        for (int i = 0; i < NTIME; i++) m[i*BYTE_W +: BYTE_W] = field_mask(i + 1);
        return m;
    endfunction

    localparam logic [TIME_W-1:0] TIME_MASK = time_mask();
endpackage

// File: rtl/clkbank_decode.sv
module clkbank_decode
    import clkbank_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_stb,
    output logic              rd_stb
);
    localparam int UPPER_W = ADDR_W - IDX_W;

    always_comb begin
        hit    = &bus_addr[ADDR_W-1 -: UPPER_W];
        idx    = bus_addr[IDX_W-1:0];
        wr_stb = bus_en && bus_we && hit;
        rd_stb = bus_en && !bus_we && hit;
    end
endmodule

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
    import clkbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [IDX_W-1:0] idx,
    input  logic             wdata_b7,
    input  logic             wdata_b6,
    output logic             wr_bit,
    output logic             rd_bit,
    output logic             osc_bit,
    output logic             ft_bit,
    output logic             load
);
    typedef struct packed {
        logic wr;
        logic rd;
        logic osc;
        logic ft;
        logic load;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.load = 1'b0;
        if (wr_stb) begin
            if (idx == IDX_CTRL) begin
                ctrl_d.wr   = wdata_b7;
                ctrl_d.rd   = wdata_b6;
                ctrl_d.load = ctrl_q.wr && !wdata_b7;
            end else if (idx == IDX_SEC) begin
                ctrl_d.osc = wdata_b7;
            end else if (idx == IDX_DOW) begin
                ctrl_d.ft = wdata_b6;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign wr_bit  = ctrl_q.wr;
    assign rd_bit  = ctrl_q.rd;
    assign osc_bit = ctrl_q.osc;
    assign ft_bit  = ctrl_q.ft;
    assign load    = ctrl_q.load;
endmodule

// File: rtl/clkbank_hold.sv
module clkbank_hold
    import clkbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              freeze,
    input  logic [TIME_W-1:0] live,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [TIME_W-1:0] hold
);
    typedef struct packed {
        logic [NTIME-1:0][BYTE_W-1:0] f;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (tick && !freeze) begin
            for (int i = 0; i < NTIME; i++)
                hold_d.f[i] = live[i*BYTE_W +: BYTE_W] & field_mask(i + 1);
        end
        if (wr_en) begin
            for (int i = 0; i < NTIME; i++) begin
                if (wr_idx == IDX_W'(i + 1)) hold_d.f[i] = wr_data & field_mask(i + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold = hold_q;
endmodule

// File: rtl/clkbank_rdmux.sv
module clkbank_rdmux
    import clkbank_pkg::*;
(
    input  logic              rd_stb,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TIME_W-1:0] hold,
    input  logic              wr_bit,
    input  logic              rd_bit,
    input  logic              osc_bit,
    input  logic              ft_bit,
    input  logic              tone,
    output logic [BYTE_W-1:0] rdata
);
    logic [NTIME-1:0][BYTE_W-1:0] fld;
    logic                         sec_lsb;

    generate
        for (genvar g = 0; g < NTIME; g++) begin : g_unpack
            assign fld[g] = hold[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    assign sec_lsb = (ft_bit && !osc_bit) ? tone : fld[0][0];

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (idx == IDX_CTRL) begin
                rdata = {wr_bit, rd_bit, {(BYTE_W-2){1'b0}}};
            end else if (idx == IDX_SEC) begin
                rdata = {osc_bit, fld[0][BYTE_W-2:1], sec_lsb};
            end else if (idx == IDX_DOW) begin
                rdata = {1'b0, ft_bit, fld[3][BYTE_W-3:0]};
            end else begin
                for (int i = 1; i < NTIME; i++) begin
                    if (idx == IDX_W'(i + 1)) rdata = fld[i];
                end
            end
        end
    end
endmodule

// File: rtl/clkbank_top.sv
module clkbank_top
    import clkbank_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 bus_hit,
    input  logic                 sec_tick,
    input  logic                 test_tone,
    input  logic [55:0]          live_time,
    output logic                 load_stb,
    output logic [55:0]          load_time,
    output logic                 osc_stop,
    output logic                 freq_test
);
    logic             wr_stb, rd_stb;
    logic [IDX_W-1:0] idx;
    logic             wr_bit_q, rd_bit_q, osc_q, ft_q, load_q;
    logic [TIME_W-1:0] hold_time;
    logic             freeze;

    clkbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_en  (bus_en),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .hit     (bus_hit),
        .idx     (idx),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    clkbank_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .idx     (idx),
        .wdata_b7(bus_wdata[7]),
        .wdata_b6(bus_wdata[6]),
        .wr_bit  (wr_bit_q),
        .rd_bit  (rd_bit_q),
        .osc_bit (osc_q),
        .ft_bit  (ft_q),
        .load    (load_q)
    );

    assign freeze = wr_bit_q || rd_bit_q || load_q;

    clkbank_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .freeze (freeze),
        .live   (live_time),
        .wr_en  (wr_stb && wr_bit_q),
        .wr_idx (idx),
        .wr_data(bus_wdata),
        .hold   (hold_time)
    );

    clkbank_rdmux u_rdmux (
        .rd_stb (rd_stb),
        .idx    (idx),
        .hold   (hold_time),
        .wr_bit (wr_bit_q),
        .rd_bit (rd_bit_q),
        .osc_bit(osc_q),
        .ft_bit (ft_q),
        .tone   (test_tone),
        .rdata  (bus_rdata)
    );

    assign load_stb  = load_q;
    assign load_time = hold_time;
    assign osc_stop  = osc_q;
    assign freq_test = ft_q;
endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk
    import clkbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_hit,
    input logic              bus_en,
    input logic              bus_we,
    input logic [IDX_W-1:0]  bus_idx,
    input logic [7:0]        bus_rdata,
    input logic              sec_tick,
    input logic [TIME_W-1:0] live_time,
    input logic              load_stb,
    input logic              wr_bit,
    input logic              rd_bit,
    input logic [TIME_W-1:0] hold
);
    a_r1_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |-> bus_rdata == '0);

    a_r2_tracks_live: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !rd_bit && !wr_bit && !load_stb) |=> hold == ($past(live_time) & TIME_MASK));

    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bit && !wr_bit) |=> $stable(hold));

    a_r5_write_halts_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bit && !(bus_en && bus_we && bus_hit)) |=> $stable(hold));

    a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    a_r6_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> ($past(wr_bit) && !wr_bit));

    a_r7_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_hit && bus_idx == IDX_CTRL) |-> bus_rdata[5:0] == 6'd0);
endmodule

bind clkbank_top clkbank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_hit  (bus_hit),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_idx  (bus_addr[2:0]),
    .bus_rdata(bus_rdata),
    .sec_tick (sec_tick),
    .live_time(live_time),
    .load_stb (load_stb),
    .wr_bit   (wr_bit_q),
    .rd_bit   (rd_bit_q),
    .hold     (hold_time)
);

// File: tb/clkbank_top_tb.sv
module clkbank_top_tb;
    localparam int AW = 11;
    localparam logic [AW-1:0] BASE = 11'h7F8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_en = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_hit;
    logic          sec_tick = 0, test_tone = 0;
    logic [55:0]   live_time = '0;
    logic          load_stb;
    logic [55:0]   load_time;
    logic          osc_stop, freq_test;

    int checks = 0;
    int fails  = 0;
    int fw[1:7] = '{7, 7, 6, 3, 6, 5, 8};

    always #2 clk = ~clk;

    clkbank_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hit(bus_hit), .sec_tick(sec_tick), .test_tone(test_tone),
        .live_time(live_time), .load_stb(load_stb), .load_time(load_time),
        .osc_stop(osc_stop), .freq_test(freq_test)
    );

    function automatic logic [7:0] msk(input int r);
        return 8'((1 << fw[r]) - 1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1;
        d = bus_rdata; h = bus_hit;
        bus_en = 0;
    endtask

    task automatic tick(input logic [55:0] v);
        @(negedge clk);
        live_time = v; sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
    endtask

    task automatic rd_chk(input string req, input int r, input logic [7:0] exp);
        logic [7:0] d; logic h;
        rd(BASE + AW'(r), d, h);
        chk(req, d, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0]  d;
        logic        h;
        logic [55:0] snap, pat;

        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        for (int r = 0; r < 8; r++) rd_chk("R11", r, 8'h00);
        chk("R11 load", load_stb, 0);
        chk("R11 osc", osc_stop, 0);
        chk("R11 ft", freq_test, 0);

        // R1 full address sweep
        for (int a = 0; a < 2048; a++) begin
            rd(AW'(a), d, h);
            chk("R1 hit", h, (a >= 'h7F8));
            if (a < 'h7F8) chk("R1 data", d, 0);
        end
        wr(11'h3F8, 8'hC0);
        rd_chk("R1 alias ctrl", 0, 8'h00);

        // R2 tracking sweep
        for (int k = 0; k < 32; k++) begin
            for (int i = 0; i < 7; i++) pat[i*8 +: 8] = 8'((k * 29 + i * 71 + 5) & 255);
            tick(pat);
            for (int r = 1; r < 8; r++) rd_chk("R2", r, pat[(r-1)*8 +: 8] & msk(r));
        end
        snap = pat;

        // R3 freeze, R7 ctrl readback
        wr(BASE, 8'h40);
        rd_chk("R7 rd bit", 0, 8'h40);
        tick(56'h11_22_33_04_05_06_07);
        for (int r = 1; r < 8; r++) rd_chk("R3", r, snap[(r-1)*8 +: 8] & msk(r));

        // R4 no snap on clear, resume on tick
        wr(BASE, 8'h00);
        rd_chk("R4 no snap", 2, snap[15:8] & msk(2));
        tick(56'h24_06_15_03_12_30_45);
        rd_chk("R4 resume", 2, 8'h30);
        rd_chk("R4 resume", 7, 8'h24);

        // R5 writes ignored with halt-for-write clear
        wr(BASE + 2, 8'h55);
        rd_chk("R5 ignored", 2, 8'h30);

        // R5/R8 write mode, all-ones per field
        wr(BASE, 8'h80);
        rd_chk("R7 wr bit", 0, 8'h80);
        for (int r = 1; r < 8; r++) wr(BASE + AW'(r), 8'hFF);
        rd_chk("R8 sec", 1, 8'hFF);
        for (int r = 2; r < 8; r++) rd_chk("R8", r, (r == 4) ? 8'h47 : msk(r));
        tick(56'h0);
        rd_chk("R5 tick ignored", 7, 8'hFF);

        // R6 bulk load
        wr(BASE + 1, 8'h45); wr(BASE + 2, 8'h30); wr(BASE + 3, 8'h12);
        wr(BASE + 4, 8'h03); wr(BASE + 5, 8'h15); wr(BASE + 6, 8'h06);
        wr(BASE + 7, 8'h99);
        chk("R6 no early load", load_stb, 0);
        wr(BASE, 8'h00);
        chk("R6 strobe", load_stb, 1);
        chk("R6 values", load_time, 56'h99_06_15_03_12_30_45);
        @(negedge clk);
        chk("R6 one cycle", load_stb, 0);

        // R9 oscillator stop flag
        wr(BASE + 1, 8'h80);
        chk("R9 out", osc_stop, 1);
        rd_chk("R9 read", 1, 8'hC5);
        wr(BASE + 1, 8'h00);
        chk("R9 clear", osc_stop, 0);

        // R10 frequency test tone
        wr(BASE + 4, 8'h40);
        chk("R10 out", freq_test, 1);
        rd_chk("R10 day", 4, 8'h43);
        test_tone = 0;
        rd_chk("R10 tone0", 1, 8'h44);
        test_tone = 1;
        rd_chk("R10 tone1", 1, 8'h45);
        test_tone = 0;
        wr(BASE + 1, 8'h80);
        rd_chk("R10 osc stopped", 1, 8'hC5);
        wr(BASE + 1, 8'h00);
        wr(BASE + 4, 8'h00);
        chk("R10 clear", freq_test, 0);

        finish_run();
    end
endmodule